// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides its input clock by an integer ratio and drives a single divided clock. Two 4-bit fields set the length of the high phase and the length of the low phase on their own, so both ratio and duty cycle are programmable. With a high field N and a low field M the ratio is N + M + 2, which covers every ratio from 2 to 32. Ratio 1 is reached through a bypass that passes the input clock straight to the output.

For odd ratios with M = N + 1, an optional correction stretches the high phase by half an input cycle and shortens the low phase by the same amount, giving a 50% duty cycle. A restart input realigns the divider. After a restart the output first holds a selectable starting level for a programmable number of extra input cycles, from 0 to 15, and then runs its phases. The configuration inputs are treated as static between restarts.

Top module: `dcycle_divider`

## Requirements
- R1: With `hi_len_i` = N and `lo_len_i` = M (4-bit each), bypass and correction off, the divided clock is high for N+1 and low for M+1 input cycles, so the ratio is N+M+2 (2 to 32).
- R2: Asymmetric settings (N != M) are honoured exactly. For example, ratio 5 may be 1 high / 4 low (N=0, M=3) or 3 high / 2 low (N=2, M=1).
- R3: While `bypass_i` is 1, `clk_o` equals `clk_i` (ratio 1), whatever the other configuration inputs hold.
- R4: With `dcc_en_i` = 1 and M = N+1, the high phase lasts N+1.5 input cycles and the low phase lasts M+0.5 cycles (50% duty). The extra half cycle ends on the falling input edge that follows the divider's high-to-low step.
- R5: With `dcc_en_i` = 1 but M != N+1, the correction has no effect and the widths are as in R1.
- R6: `sync_i` is active high and sampled on the rising edge of `clk_i`. The rising edge that sees it high restarts the divider and clears any pending correction.
- R7: After a restart the output starts high when `start_hi_i` = 1 and runs the high phase first. When `start_hi_i` = 0 it starts low and runs the low phase first.
- R8: With delay P (`dly_i`, 4-bit), the first output edge after the restart edge comes P+N+1 input cycles later when starting high, or P+M+1 cycles later when starting low. Correction, when active, adds half a cycle to a first falling edge.
- R9: A delay larger than the ratio minus one is treated as ratio minus one.
- R10: While `rst_ni` is low (asynchronous, active low) and bypass is off, `clk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Synchronous restart, active high |
| bypass_i | input | 1 | Pass `clk_i` straight to `clk_o` |
| hi_len_i | input | 4 | High phase length minus one (N) |
| lo_len_i | input | 4 | Low phase length minus one (M) |
| dly_i | input | 4 | Start delay in input cycles (P) |
| start_hi_i | input | 1 | Level taken on restart (1 = high) |
| dcc_en_i | input | 1 | Enable half-cycle duty correction |
| clk_o | output | 1 | Divided clock |

## Verification
The output is sampled twice per input cycle, so each measured width and first-edge time resolves half cycles. A short table tries asymmetric ratio-5 splits against each other, an odd ratio with correction against an even one where correction must stay idle, and large delays against small ratios to separate clamping from plain delay. An exhaustive sweep then covers every N and M pair with correction on and off, varying delay and start level. This exposes any off-by-one in either phase and any half cycle appearing where it does not belong. Directed steps check the output level during reset and confirm that bypass follows the input clock while the phase fields change.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
package dcd_pkg;

   // Level of the divided clock while a phase is running.
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   // Bits needed to hold a full ratio (two phase fields plus two).
   function automatic int unsigned div_width(input int unsigned half_w);
      return half_w + 2;
   endfunction

endpackage

// File: rtl/dcd_start_delay.sv
`timescale 1ns/1ps
module dcd_start_delay #(
   parameter int unsigned HALF_W = 4,
   parameter int unsigned DLY_W  = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sync_i,
   input  logic [HALF_W-1:0] hi_len_i,
   input  logic [HALF_W-1:0] lo_len_i,
   input  logic [DLY_W-1:0]  dly_i,
   output logic              hold_o
);

   localparam int unsigned DIV_W = dcd_pkg::div_width(HALF_W);
   localparam int unsigned CMP_W = (DIV_W > DLY_W) ? DIV_W : DLY_W;

   if (DLY_W < 1 || DLY_W > 8) begin : g_bad_dly_w
      $error("dcd_start_delay: DLY_W must lie in 1..8");
   end

   logic [CMP_W-1:0] ratio_w;
   logic [CMP_W-1:0] lim_w;
   logic [CMP_W-1:0] req_w;
   logic [DLY_W-1:0] eff_dly;
   logic [DLY_W-1:0] cnt_q;

   // Largest useful delay is one less than the ratio.
   assign ratio_w = CMP_W'(hi_len_i) + CMP_W'(lo_len_i) + CMP_W'(2);
   assign lim_w   = ratio_w - CMP_W'(1);
   assign req_w   = CMP_W'(dly_i);
   assign eff_dly = (req_w > lim_w) ? DLY_W'(lim_w) : dly_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (sync_i) begin
         cnt_q <= eff_dly;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign hold_o = (cnt_q != '0);

   // R9: a loaded delay never exceeds the request or ratio-1
   p_load_clamped_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_i |=> ((CMP_W'(cnt_q) <= $past(lim_w)) && (cnt_q <= $past(dly_i))));

   // R8: the delay drains by one per input cycle
   p_countdown_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sync_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/dcd_phase_gen.sv
`timescale 1ns/1ps
module dcd_phase_gen
   import dcd_pkg::*;
#(
   parameter int unsigned HALF_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sync_i,
   input  logic              start_hi_i,
   input  logic              advance_i,
   input  logic [HALF_W-1:0] hi_len_i,
   input  logic [HALF_W-1:0] lo_len_i,
   output logic              lvl_o,
   output logic              fall_o
);

   if (HALF_W < 1 || HALF_W > 6) begin : g_bad_half_w
      $error("dcd_phase_gen: HALF_W must lie in 1..6");
   end

   phase_e            lvl_q;
   logic [HALF_W-1:0] cnt_q;
   logic [HALF_W-1:0] cur_len;
   logic              at_end;
   logic              fall_q;

   assign cur_len = (lvl_q == PH_HIGH) ? hi_len_i : lo_len_i;
   assign at_end  = (cnt_q == cur_len);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lvl_q  <= PH_LOW;
         cnt_q  <= '0;
         fall_q <= 1'b0;
      end else if (sync_i) begin
         lvl_q  <= start_hi_i ? PH_HIGH : PH_LOW;
         cnt_q  <= '0;
         fall_q <= 1'b0;
      end else if (advance_i && at_end) begin
         lvl_q  <= (lvl_q == PH_HIGH) ? PH_LOW : PH_HIGH;
         cnt_q  <= '0;
         fall_q <= (lvl_q == PH_HIGH);
      end else if (advance_i) begin
         cnt_q  <= cnt_q + 1'b1;
         fall_q <= 1'b0;
      end else begin
         fall_q <= 1'b0;
      end
   end

   assign lvl_o  = (lvl_q == PH_HIGH);
   assign fall_o = fall_q;

   // R6, R7: restart loads the requested start level
   p_start_level_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_i |=> (lvl_q == ($past(start_hi_i) ? PH_HIGH : PH_LOW)));

   // R4: the fall marker only follows a true high-to-low step
   p_fall_marks_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_q |-> ((lvl_q == PH_LOW) && ($past(lvl_q) == PH_HIGH)));

   // R1: every phase change starts the next phase count from zero
   p_phase_restart_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_q != $past(lvl_q)) |-> (cnt_q == '0));

endmodule

// File: rtl/dcd_half_ext.sv
`timescale 1ns/1ps
module dcd_half_ext (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   input  logic fall_i,
   input  logic ext_en_i,
   output logic clk_o
);

   logic neg_q;

   // Copy of the level taken half a cycle late.
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         neg_q <= 1'b0;
      end else begin
         neg_q <= lvl_i;
      end
   end

   assign clk_o = lvl_i | (ext_en_i & fall_i & neg_q);

   // R4: the falling-edge copy matches the level seen at each rising edge
   p_neg_tracks_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      neg_q == lvl_i);

endmodule

// File: rtl/dcycle_divider.sv
`timescale 1ns/1ps
module dcycle_divider #(
   parameter int unsigned HALF_W     = 4,
   parameter int unsigned DLY_W      = 4,
   parameter bit          HAS_BYPASS = 1'b1,
   parameter bit          HAS_DCC    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sync_i,
   input  logic              bypass_i,
   input  logic [HALF_W-1:0] hi_len_i,
   input  logic [HALF_W-1:0] lo_len_i,
   input  logic [DLY_W-1:0]  dly_i,
   input  logic              start_hi_i,
   input  logic              dcc_en_i,
   output logic              clk_o
);

   localparam int unsigned LEN1_W = HALF_W + 1;

   if (HALF_W < 1 || HALF_W > 6) begin : g_bad_half_w
      $error("dcycle_divider: HALF_W must lie in 1..6");
   end
   if (DLY_W < 1 || DLY_W > 8) begin : g_bad_dly_w
      $error("dcycle_divider: DLY_W must lie in 1..8");
   end

   logic hold;
   logic lvl;
   logic fall;
   logic div_clk;

   dcd_start_delay #(
      .HALF_W (HALF_W),
      .DLY_W  (DLY_W)
   ) u_delay (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sync_i   (sync_i),
      .hi_len_i (hi_len_i),
      .lo_len_i (lo_len_i),
      .dly_i    (dly_i),
      .hold_o   (hold)
   );

   dcd_phase_gen #(
      .HALF_W (HALF_W)
   ) u_phase (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_i     (sync_i),
      .start_hi_i (start_hi_i),
      .advance_i  (!hold),
      .hi_len_i   (hi_len_i),
      .lo_len_i   (lo_len_i),
      .lvl_o      (lvl),
      .fall_o     (fall)
   );

   if (HAS_DCC) begin : g_dcc
      logic dcc_ok;
      // Correction only applies when low = high + 1 (odd ratio).
      assign dcc_ok = dcc_en_i &&
                      (LEN1_W'(lo_len_i) == (LEN1_W'(hi_len_i) + LEN1_W'(1)));

      dcd_half_ext u_ext (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .lvl_i    (lvl),
         .fall_i   (fall),
         .ext_en_i (dcc_ok),
         .clk_o    (div_clk)
      );
   end else begin : g_no_dcc
      assign div_clk = lvl;
   end

   if (HAS_BYPASS) begin : g_bypass
      assign clk_o = bypass_i ? clk_i : div_clk;
   end else begin : g_no_bypass
      assign clk_o = div_clk;
   end

   // R8: while the start delay runs, the level is frozen
   p_hold_freezes_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold && !sync_i) |=> $stable(lvl));

endmodule

// File: tb/tb_dcycle_divider.sv
`timescale 1ns/1ps
module tb_dcycle_divider;

   localparam int WIN  = 160;
   localparam int NVEC = 9;

   typedef struct packed {
      logic [3:0] n;
      logic [3:0] m;
      logic [3:0] p;
      logic       sh;
      logic       dcc;
      logic [7:0] ef;
      logic [7:0] ew2;
      logic [7:0] ew3;
   } vec_t;

   // Expected first-change index and the next two run lengths, in half cycles.
   localparam vec_t VECS [NVEC] = '{
      '{4'd0,  4'd3,  4'd0,  1'b1, 1'b0, 8'd2,  8'd8,  8'd2 },  // R2 ratio 5, 1 high / 4 low
      '{4'd2,  4'd1,  4'd0,  1'b1, 1'b0, 8'd6,  8'd4,  8'd6 },  // R2 ratio 5, 3 high / 2 low
      '{4'd1,  4'd2,  4'd0,  1'b1, 1'b1, 8'd5,  8'd5,  8'd5 },  // R4 corrected ratio 5
      '{4'd1,  4'd2,  4'd0,  1'b0, 1'b1, 8'd6,  8'd5,  8'd5 },  // R4, R7 start low
      '{4'd3,  4'd3,  4'd0,  1'b1, 1'b1, 8'd8,  8'd8,  8'd8 },  // R5 even ratio, no correction
      '{4'd0,  4'd0,  4'd15, 1'b1, 1'b0, 8'd4,  8'd2,  8'd2 },  // R9 delay clamped to 1
      '{4'd7,  4'd7,  4'd15, 1'b0, 1'b0, 8'd46, 8'd16, 8'd16},  // R8 full delay
      '{4'd15, 4'd15, 4'd5,  1'b1, 1'b0, 8'd42, 8'd32, 8'd32},  // R1 ratio 32
      '{4'd14, 4'd15, 4'd0,  1'b1, 1'b1, 8'd31, 8'd31, 8'd31}   // R4 ratio 31
   };

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       sync_i = 1'b0;
   logic       bypass_i = 1'b0;
   logic [3:0] hi_len_i = 4'd0;
   logic [3:0] lo_len_i = 4'd0;
   logic [3:0] dly_i = 4'd0;
   logic       start_hi_i = 1'b0;
   logic       dcc_en_i = 1'b0;
   logic       clk_o;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   logic smp [WIN];

   dcycle_divider dut (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_i     (sync_i),
      .bypass_i   (bypass_i),
      .hi_len_i   (hi_len_i),
      .lo_len_i   (lo_len_i),
      .dly_i      (dly_i),
      .start_hi_i (start_hi_i),
      .dcc_en_i   (dcc_en_i),
      .clk_o      (clk_o)
   );

   always #4 clk_i = ~clk_i;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_case(input logic [3:0] n, input logic [3:0] m, input logic [3:0] p,
                           input logic sh, input logic dcc,
                           input int ef, input int ew2, input int ew3,
                           input string rq_first, input string rq_w);
      int   f;
      int   w2;
      int   w3;
      int   idx;
      logic v0;
      @(posedge clk_i); #2;
      hi_len_i = n; lo_len_i = m; dly_i = p; start_hi_i = sh; dcc_en_i = dcc;
      sync_i = 1'b1;
      @(posedge clk_i); #1;
      smp[0] = clk_o;
      #1 sync_i = 1'b0;
      for (int h = 1; h < WIN; h++) begin
         if (h % 2 == 1) begin
            @(negedge clk_i); #1;
         end else begin
            @(posedge clk_i); #1;
         end
         smp[h] = clk_o;
      end
      v0 = smp[0];
      f = -1;
      for (int h = 1; h < WIN; h++) begin
         if (f < 0 && smp[h] != v0) f = h;
      end
      w2 = 0;
      w3 = 0;
      if (f > 0) begin
         idx = f;
         while (idx < WIN && smp[idx] != v0) begin w2++; idx++; end
         while (idx < WIN && smp[idx] == v0) begin w3++; idx++; end
      end
      check(v0 == sh, "R6,R7 start level", int'(v0), int'(sh));
      check(f == ef, rq_first, f, ef);
      check(w2 == ew2, rq_w, w2, ew2);
      check(w3 == ew3, rq_w, w3, ew3);
   endtask

   initial begin
      // R10: output low while reset is held
      repeat (3) @(posedge clk_i);
      #1 check(clk_o == 1'b0, "R10 reset high half", int'(clk_o), 0);
      @(negedge clk_i); #1;
      check(clk_o == 1'b0, "R10 reset low half", int'(clk_o), 0);
      @(posedge clk_i); #2;
      rst_ni = 1'b1;
      #1 check(clk_o == 1'b0, "R10 just after release", int'(clk_o), 0);

      // Table walk
      for (int i = 0; i < NVEC; i++) begin
         vec_t v;
         string rw;
         v = VECS[i];
         if (v.dcc && ({1'b0, v.m} == {1'b0, v.n} + 5'd1)) rw = "R4 width";
         else if (v.dcc) rw = "R5 width";
         else if (v.n != v.m) rw = "R2 width";
         else rw = "R1 width";
         run_case(v.n, v.m, v.p, v.sh, v.dcc, int'(v.ef), int'(v.ew2), int'(v.ew3),
                  (int'(v.p) > int'(v.n) + int'(v.m) + 1) ? "R9 first edge" : "R8 first edge", rw);
      end

      // Exhaustive sweep of every N, M pair with correction off and on
      for (int n = 0; n < 16; n++) begin
         for (int m = 0; m < 16; m++) begin
            for (int d = 0; d < 2; d++) begin
               int    p;
               int    pe;
               int    ext;
               int    hh;
               int    lh;
               int    ef;
               int    e2;
               int    e3;
               bit    sh;
               string rw;
               p   = (n * 3 + m * 5 + d) % 16;
               sh  = ((n + m + d) % 2) == 1;
               pe  = (p > n + m + 1) ? n + m + 1 : p;
               ext = (d == 1 && m == n + 1) ? 1 : 0;
               hh  = 2 * (n + 1) + ext;
               lh  = 2 * (m + 1) - ext;
               if (sh) begin
                  ef = 2 * (pe + n + 1) + ext; e2 = lh; e3 = hh;
               end else begin
                  ef = 2 * (pe + m + 1); e2 = hh; e3 = lh;
               end
               if (ext == 1) rw = "R4 width";
               else if (d == 1) rw = "R5 width";
               else if (n != m) rw = "R2 width";
               else rw = "R1 width";
               run_case(4'(n), 4'(m), 4'(p), sh, d[0], ef, e2, e3,
                        (p > n + m + 1) ? "R9 first edge" : "R8 first edge", rw);
            end
         end
      end

      // R3: bypass follows the input clock while phase fields change
      @(posedge clk_i); #2;
      bypass_i = 1'b1;
      for (int k = 0; k < 4; k++) begin
         hi_len_i = 4'(k * 5);
         lo_len_i = 4'(k * 3 + 1);
         @(posedge clk_i); #1;
         check(clk_o == 1'b1, "R3 bypass high half", int'(clk_o), 1);
         @(negedge clk_i); #1;
         check(clk_o == 1'b0, "R3 bypass low half", int'(clk_o), 0);
      end
      bypass_i = 1'b0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule